// File: doc/BRIEF.md
# Misaligned-Tolerant Load/Store Unit

This block sits between the memory stage of a 32-bit in-order pipeline and an external data RAM with asynchronous read. For every load or store request it checks the alignment of the byte address against the access size. It then registers a command for a word-addressed RAM port: a read strobe, a write strobe, a byte-write strobe and a 2-bit lane selector. For byte and halfword loads it picks the addressed field out of the returned word and sign- or zero-extends it to the full data width.

Alignment is reported through a sticky-until-next-access status bit and never through a trap. A misaligned word or halfword access still runs, with its low address bits forced down to the natural boundary. The RAM is big-endian: lane 0 is the most significant byte. A byte store drives the store byte on every lane and raises the byte-write strobe. The RAM then updates only the selected lane and keeps the other three.

Top module: `mem_align_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ram_rd`, `ram_wr`, `ram_wbyte`, `load_valid` and `unaligned_flag` are 0.
- R2: Operation codes on `req_op` are LW=0, LH=1, LHU=2, LB=3, LBU=4, SW=5, SB=6. A word access (LW, SW) whose address has bits 1:0 not equal to 00 sets `unaligned_flag`. An aligned word access clears it.
- R3: A halfword load (LH, LHU) with address bit 0 set raises `unaligned_flag`. One with bit 0 clear clears it.
- R4: Byte accesses (LB, LBU, SB) are legal at every byte offset and always clear `unaligned_flag`.
- R5: `unaligned_flag` changes on the clock edge that accepts a request, so it is readable in the following cycle. On cycles without a request it holds its value.
- R6: The edge that accepts a request drives exactly one cycle of `ram_rd` (loads) or `ram_wr` (stores), never both. `ram_addr` equals `req_addr` with its two low bits dropped.
- R7: For SB, `ram_wbyte` is 1, `ram_lane` equals address bits 1:0, and `ram_wdata` carries the store byte `req_wdata[7:0]` in all four lanes. For SW, `ram_wbyte` is 0, `ram_lane` is 0 and `ram_wdata` equals `req_wdata`.
- R8: Lane numbering is big-endian: lane 0 is bits 31:24 and lane 3 is bits 7:0. Loads report their lane on `ram_lane`: 0 for words, address bit 1 followed by 0 for halfwords, and address bits 1:0 for bytes.
- R9: LB returns the addressed byte sign-extended to 32 bits. LBU returns it zero-extended.
- R10: LH returns the addressed halfword sign-extended and LHU returns it zero-extended. Address bit 1 = 0 selects bits 31:16 and 1 selects bits 15:0.
- R11: A misaligned LW, SW, LH or LHU still completes, using the address with its low bits cleared to the access size: the full word for LW/SW, the halfword chosen by bit 1 for LH/LHU.
- R12: `load_valid` pulses for one cycle on the edge after `ram_rd`, together with the extracted `load_data`, two edges after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wbyte | output | 1 | Store only the selected lane |
| ram_lane | output | 2 | Big-endian byte lane selector |
| ram_addr | output | ADDR_W-2 | Word address |
| ram_wdata | output | DATA_W | Data towards RAM |
| ram_rdata | input | DATA_W | Word returned by RAM (asynchronous) |
| load_valid | output | 1 | Load result valid |
| load_data | output | DATA_W | Extended load result |
| unaligned_flag | output | 1 | Alignment status of the latest access |

## Verification
The checker watches every cycle for several properties. It confirms that read and write strobes are exclusive and single-cycle per request, and that the byte-write strobe appears only with a write. It checks that the flag follows the alignment rule of each access and holds when idle, and that word accesses select lane 0. It also confirms that a load result follows each read one edge later. Only the bench's sweeps can show the data path: the bytes and halfwords extracted with the right extension at every offset, and byte stores that leave neighbouring lanes intact. The bench also shows that misaligned accesses land on the forced-down address. Each of these needs a memory image to compare against.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [2:0] {
    OP_LW  = 3'd0,
    OP_LH  = 3'd1,
    OP_LHU = 3'd2,
    OP_LB  = 3'd3,
    OP_LBU = 3'd4,
    OP_SW  = 3'd5,
    OP_SB  = 3'd6,
    OP_NONE = 3'd7
  } mem_op_e;

  typedef enum logic [1:0] {
    SZ_WORD,
    SZ_HALF,
    SZ_BYTE
  } acc_size_e;

  function automatic acc_size_e op_size(mem_op_e op);
    case (op)
      OP_LW, OP_SW:  return SZ_WORD;
      OP_LH, OP_LHU: return SZ_HALF;
      default:       return SZ_BYTE;
    endcase
  endfunction

  function automatic logic op_is_load(mem_op_e op);
    return (op == OP_LW) || (op == OP_LH) || (op == OP_LHU) ||
           (op == OP_LB) || (op == OP_LBU);
  endfunction

  function automatic logic op_is_store(mem_op_e op);
    return (op == OP_SW) || (op == OP_SB);
  endfunction

  function automatic logic op_is_signed(mem_op_e op);
    return (op == OP_LH) || (op == OP_LB);
  endfunction

endpackage

// File: rtl/mau_align_check.sv
module mau_align_check
  import mau_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  mem_op_e             op,
  input  logic [LANE_W-1:0]   offs,
  output logic                misaligned,
  output logic [LANE_W-1:0]   lane
);

  always_comb begin
    misaligned = 1'b0;
    lane       = offs;
    case (op_size(op))
      SZ_WORD: begin
        misaligned = |offs;
        lane       = '0;
      end
      SZ_HALF: begin
        misaligned = offs[0];
        lane       = {offs[LANE_W-1:1], 1'b0};
      end
      default: begin
        misaligned = 1'b0;
        lane       = offs;
      end
    endcase
  end

endmodule

// File: rtl/mau_cmd_reg.sv
module mau_cmd_reg
  import mau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NLANES = DATA_W / 8,
  localparam int LANE_W = $clog2(NLANES),
  localparam int WA_W   = ADDR_W - LANE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  mem_op_e            op,
  input  logic [WA_W-1:0]    word_addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               misaligned,
  input  logic [LANE_W-1:0]  lane,
  output logic               ram_rd,
  output logic               ram_wr,
  output logic               ram_wbyte,
  output logic [LANE_W-1:0]  ram_lane,
  output logic [WA_W-1:0]    ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  output logic               flag,
  output mem_op_e            pend_op
);

  logic              is_ld;
  logic              is_st;
  logic              access;
  logic [DATA_W-1:0] byte_rep;

  assign is_ld  = op_is_load(op);
  assign is_st  = op_is_store(op);
  assign access = req_valid && (is_ld || is_st);

  for (genvar g = 0; g < NLANES; g++) begin : g_rep
    assign byte_rep[g*8 +: 8] = wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_rd    <= 1'b0;
      ram_wr    <= 1'b0;
      ram_wbyte <= 1'b0;
      ram_lane  <= '0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      flag      <= 1'b0;
      pend_op   <= OP_NONE;
    end else begin
      ram_rd    <= access && is_ld;
      ram_wr    <= access && is_st;
      ram_wbyte <= access && (op == OP_SB);
      if (access) begin
        ram_lane  <= lane;
        ram_addr  <= word_addr;
        ram_wdata <= (op == OP_SB) ? byte_rep : wdata;
        flag      <= misaligned;
        pend_op   <= op;
      end
    end
  end

endmodule

// File: rtl/mau_load_extract.sv
module mau_load_extract
  import mau_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NLANES = DATA_W / 8,
  localparam int NHALF  = NLANES / 2,
  localparam int LANE_W = $clog2(NLANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_done,
  input  mem_op_e            op,
  input  logic [LANE_W-1:0]  lane,
  input  logic [DATA_W-1:0]  rdata,
  output logic               load_valid,
  output logic [DATA_W-1:0]  load_data
);

  logic [7:0]        lane_b [NLANES];
  logic [15:0]       lane_h [NHALF];
  logic [7:0]        sel_b;
  logic [15:0]       sel_h;
  logic              sx;
  logic [DATA_W-1:0] ext;

  // big-endian: lane 0 holds the most significant byte
  for (genvar g = 0; g < NLANES; g++) begin : g_byte
    assign lane_b[g] = rdata[DATA_W-1-8*g -: 8];
  end
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign lane_h[h] = rdata[DATA_W-1-16*h -: 16];
  end

  assign sel_b = lane_b[lane];
  assign sel_h = lane_h[lane[LANE_W-1:1]];
  assign sx    = op_is_signed(op);

  always_comb begin
    case (op_size(op))
      SZ_WORD: ext = rdata;
      SZ_HALF: ext = {{(DATA_W-16){sx & sel_h[15]}}, sel_h};
      default: ext = {{(DATA_W-8){sx & sel_b[7]}}, sel_b};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_valid <= 1'b0;
      load_data  <= '0;
    end else begin
      load_valid <= rd_done;
      if (rd_done) load_data <= ext;
    end
  end

endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit
  import mau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANE_W = $clog2(DATA_W / 8),
  localparam int WA_W   = ADDR_W - LANE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               ram_rd,
  output logic               ram_wr,
  output logic               ram_wbyte,
  output logic [LANE_W-1:0]  ram_lane,
  output logic [WA_W-1:0]    ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic               load_valid,
  output logic [DATA_W-1:0]  load_data,
  output logic               unaligned_flag
);

  mem_op_e            op;
  mem_op_e            pend_op;
  logic               misaligned;
  logic [LANE_W-1:0]  lane;

  assign op = mem_op_e'(req_op);

  mau_align_check #(.LANE_W(LANE_W)) u_align (
    .op         (op),
    .offs       (req_addr[LANE_W-1:0]),
    .misaligned (misaligned),
    .lane       (lane)
  );

  mau_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .op         (op),
    .word_addr  (req_addr[ADDR_W-1:LANE_W]),
    .wdata      (req_wdata),
    .misaligned (misaligned),
    .lane       (lane),
    .ram_rd     (ram_rd),
    .ram_wr     (ram_wr),
    .ram_wbyte  (ram_wbyte),
    .ram_lane   (ram_lane),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .flag       (unaligned_flag),
    .pend_op    (pend_op)
  );

  mau_load_extract #(.DATA_W(DATA_W)) u_ext (
    .clk        (clk),
    .rst        (rst),
    .rd_done    (ram_rd),
    .op         (pend_op),
    .lane       (ram_lane),
    .rdata      (ram_rdata),
    .load_valid (load_valid),
    .load_data  (load_data)
  );

endmodule

// File: rtl/mau_checker.sv
module mau_checker
  import mau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANE_W = $clog2(DATA_W / 8),
  localparam int WA_W   = ADDR_W - LANE_W
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [2:0]         req_op,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               ram_rd,
  input logic               ram_wr,
  input logic               ram_wbyte,
  input logic [LANE_W-1:0]  ram_lane,
  input logic [WA_W-1:0]    ram_addr,
  input logic               load_valid,
  input logic               unaligned_flag
);

  logic word_op, half_op, byte_op;
  assign word_op = (req_op == OP_LW) || (req_op == OP_SW);
  assign half_op = (req_op == OP_LH) || (req_op == OP_LHU);
  assign byte_op = (req_op == OP_LB) || (req_op == OP_LBU) || (req_op == OP_SB);

  p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(ram_rd && ram_wr));

  p_idle_no_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ram_rd && !ram_wr));

  p_addr_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (word_op || half_op || byte_op)) |=>
      ram_addr == $past(req_addr[ADDR_W-1:LANE_W]));

  p_wbyte_write_r7: assert property (@(posedge clk) disable iff (rst)
    ram_wbyte |-> ram_wr);

  p_word_lane_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && word_op) |=> (ram_lane == '0));

  p_word_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && word_op) |=> (unaligned_flag == $past(|req_addr[1:0])));

  p_half_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && half_op) |=> (unaligned_flag == $past(req_addr[0])));

  p_byte_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && byte_op) |=> !unaligned_flag);

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(unaligned_flag));

  p_load_after_rd_r12: assert property (@(posedge clk) disable iff (rst)
    ram_rd |=> load_valid);

  p_valid_needs_rd_r12: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> $past(ram_rd));

endmodule

bind mem_align_unit mau_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mau_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_op         (req_op),
  .req_addr       (req_addr),
  .ram_rd         (ram_rd),
  .ram_wr         (ram_wr),
  .ram_wbyte      (ram_wbyte),
  .ram_lane       (ram_lane),
  .ram_addr       (ram_addr),
  .load_valid     (load_valid),
  .unaligned_flag (unaligned_flag)
);

// File: tb/tb_mem_align_unit.sv
`timescale 1ns/1ps
module tb_mem_align_unit;
  import mau_pkg::*;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int WA_W   = ADDR_W - 2;
  localparam int NWORDS = 1 << WA_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [2:0]        req_op = 3'd7;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              ram_rd, ram_wr, ram_wbyte;
  logic [1:0]        ram_lane;
  logic [WA_W-1:0]   ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata, load_data;
  logic              load_valid, unaligned_flag;

  logic [31:0] mem     [NWORDS];
  logic [31:0] ref_mem [NWORDS];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mem_align_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .ram_rd(ram_rd),
    .ram_wr(ram_wr), .ram_wbyte(ram_wbyte), .ram_lane(ram_lane),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .load_valid(load_valid), .load_data(load_data),
    .unaligned_flag(unaligned_flag)
  );

  // asynchronous-read RAM honouring the byte-write protocol
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) begin
    if (ram_wr) begin
      if (ram_wbyte) begin
        for (int b = 0; b < 4; b++)
          if (ram_lane == 2'(b)) mem[ram_addr][31-8*b -: 8] <= ram_wdata[31-8*b -: 8];
      end else begin
        mem[ram_addr] <= ram_wdata;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(mem_op_e op, logic [ADDR_W-1:0] a, logic [31:0] wd);
    logic [1:0]  off;
    logic [WA_W-1:0] wa;
    logic        mis;
    logic [1:0]  lane;
    logic        ld, st;
    logic [31:0] w, exp;
    logic [7:0]  b;
    logic [15:0] h;
    off = a[1:0];
    wa  = a[ADDR_W-1:2];
    ld  = op_is_load(op);
    st  = op_is_store(op);
    case (op)
      OP_LW, OP_SW:  begin mis = (off != 2'd0); lane = 2'd0; end
      OP_LH, OP_LHU: begin mis = off[0]; lane = {off[1], 1'b0}; end
      default:       begin mis = 1'b0; lane = off; end
    endcase
    w = ref_mem[wa];
    b = 8'(w >> (8 * (3 - int'(off))));
    h = off[1] ? w[15:0] : w[31:16];
    case (op)
      OP_LW:   exp = w;
      OP_LH:   exp = {{16{h[15]}}, h};
      OP_LHU:  exp = {16'h0, h};
      OP_LB:   exp = {{24{b[7]}}, b};
      OP_LBU:  exp = {24'h0, b};
      default: exp = 32'h0;
    endcase
    if (op == OP_SW) ref_mem[wa] = wd;
    if (op == OP_SB) ref_mem[wa][31-8*int'(off) -: 8] = wd[7:0];

    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2/R3/R4 flag", 32'(unaligned_flag), 32'(mis));
    chk("R6 ram_rd", 32'(ram_rd), 32'(ld));
    chk("R6 ram_wr", 32'(ram_wr), 32'(st));
    chk("R6 ram_addr", 32'(ram_addr), 32'(wa));
    chk("R8 ram_lane", 32'(ram_lane), 32'(lane));
    chk("R7 ram_wbyte", 32'(ram_wbyte), 32'(op == OP_SB));
    if (op == OP_SB) chk("R7 sb data", ram_wdata, {4{wd[7:0]}});
    if (op == OP_SW) chk("R7/R11 sw data", ram_wdata, wd);
    @(negedge clk);
    chk("R12 load_valid", 32'(load_valid), 32'(ld));
    chk("R6 single strobe", 32'(ram_rd | ram_wr), 32'd0);
    chk("R5 flag visible", 32'(unaligned_flag), 32'(mis));
    if (ld) begin
      case (op)
        OP_LW:         chk("R11 lw data", load_data, exp);
        OP_LH, OP_LHU: chk("R10 half data", load_data, exp);
        default:       chk("R9 byte data", load_data, exp);
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) begin mem[i] = 32'h0; ref_mem[i] = 32'h0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ram_rd", 32'(ram_rd), 0);
    chk("R1 ram_wr", 32'(ram_wr), 0);
    chk("R1 ram_wbyte", 32'(ram_wbyte), 0);
    chk("R1 load_valid", 32'(load_valid), 0);
    chk("R1 flag", 32'(unaligned_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flag after reset", 32'(unaligned_flag), 0);
    chk("R1 no strobe after reset", 32'(ram_rd | ram_wr), 0);

    // fill memory with aligned word stores
    for (int w = 0; w < NWORDS; w++)
      access(OP_SW, ADDR_W'(w * 4), (32'(w) * 32'h9E3779B1) ^ 32'h80F17F08);

    // sweep all operations over all offsets of every word
    for (int w = 0; w < NWORDS; w++)
      for (int off = 0; off < 4; off++)
        for (int o = 0; o < 7; o++)
          access(mem_op_e'(o), ADDR_W'(w * 4 + off),
                 32'h5A000000 | 32'(w * 29 + off * 7 + o) ^ 32'h00A5C381);

    // R5 flag holds while idle after a misaligned access, then clears
    access(OP_LW, 8'h13, 32'h0);
    repeat (5) @(negedge clk);
    chk("R5 flag hold high", 32'(unaligned_flag), 1);
    access(OP_LB, 8'h13, 32'h0);
    repeat (5) @(negedge clk);
    chk("R5 flag hold low", 32'(unaligned_flag), 0);

    // R7 byte store keeps neighbouring lanes, observed through loads
    access(OP_SW, 8'h20, 32'h11223344);
    access(OP_SB, 8'h22, 32'hFFFFFF99);
    access(OP_LW, 8'h20, 32'h0);
    chk("R7 neighbours kept", load_data, 32'h11229944);

    // final memory comparison
    for (int w = 0; w < NWORDS; w++) chk("R7/R11 memory image", mem[w], ref_mem[w]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule